// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a group of asynchronous external request pins and records edge events on each of them. Every pin passes through a two-flop synchronizer. A transition of the synchronized level is recognised as a rising or a falling edge, and only an edge whose direction is enabled for that pin counts. A counted edge sets the pin's pending flag. When a counted edge finds the pin's pending flag still set, and overrun tracking is enabled for that pin, the pin's overrun flag is set. All overrun flags are ORed into one overrun request line. A per-pin request enable gates each pending flag onto its own request output.

Software reaches the block through a simple 32-bit register port. It has a write strobe, a byte address, write data and a combinational read-data output. Enable registers are plain read/write. The pending and overrun registers are cleared by writing ones to them. The pin count is a parameter, 16 by default, and reset clears every enable and every flag.

Top module: `ext_edge_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_req_o` and `overrun_irq_o` are 0.
- R2: With bit i of the rise-enable register (offset 0x04) set, a low-to-high change on pin i sets bit i of the pending register (offset 0x14) at the third rising clock edge after the change.
- R3: With bit i of the fall-enable register (offset 0x08) set, a high-to-low change on pin i sets pending bit i at the third rising clock edge after the change.
- R4: An edge whose direction is not enabled for a pin leaves the pending and overrun flags unchanged, and so does clearing both enables for a pin that already has its flag set.
- R5: With both enables set for a pin, both rising and falling edges set its pending bit.
- R6: Writing 1 to a bit of the pending register (0x14) or the overrun register (0x10) clears that bit. Writing 0 has no effect.
- R7: When a counted edge and a write-1 clear of the same pending bit fall on the same clock edge, the bit stays set.
- R8: A counted edge on pin i sets overrun bit i (0x10) only when pending bit i is already set and bit i of the overrun-enable register (0x0C) is 1.
- R9: `overrun_irq_o` is 1 exactly when at least one overrun bit is set.
- R10: `irq_req_o[i]` is 1 exactly when pending bit i and bit i of the request-enable register (0x00) are both 1.
- R11: Enable registers read back what was written, masked to the pin count. Bits at and above the pin count read 0, and addresses outside 0x00 to 0x14 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | NUM_PINS | Asynchronous external request pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| irq_req_o | output | NUM_PINS | Per-pin gated interrupt requests |
| overrun_irq_o | output | 1 | OR of all overrun flags |

## Verification
On every cycle the assertions check four things. A detected rising edge must match the pin level two samples earlier. Pending flags may change only where an edge or a clear arrived. A new overrun bit needs an already pending flag and an armed overrun enable. A rise of the overrun line must follow a detected edge. The bench's scenarios are needed for the rest: the three-edge latency, each enable combination swept over every pin, the same-cycle set-against-clear race, request gating, and the read-back mask of the register port.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
// Package: register offsets and widths shared by the edge interrupt controller.
package eirq_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;
    localparam logic [REG_AW-1:0] OFS_REQ_EN   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_RISE_EN  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_FALL_EN  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_OVR_EN   = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_OVR_STAT = 8'h10;
    localparam logic [REG_AW-1:0] OFS_EVT_STAT = 8'h14;
endpackage

// File: rtl/eirq_edge_detect.sv
`timescale 1ns/1ps
// Module: eirq_edge_detect
// Synchronizes each pin through two flops, keeps the previous synchronized
// level and reports an event for an enabled rising or falling transition.
// Assumes pins are idle low at reset (the history flops reset to 0).
module eirq_edge_detect #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    output logic [NUM_PINS-1:0] evt_o
);
    logic [NUM_PINS-1:0] rise_v;
    logic [NUM_PINS-1:0] fall_v;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Two-flop synchronizer followed by a one-cycle history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Edge classification from current and previous synchronized level.
        always_comb begin
            rise_v[g] = sync_q & ~prev_q;
            fall_v[g] = ~sync_q & prev_q;
        end
    end

    // Qualify edges with their per-pin direction enables.
    always_comb begin
        evt_o = (rise_v & rise_en_i) | (fall_v & fall_en_i);
    end

    // R2: a rise-only event implies the pin was high two samples earlier.
    p_rise_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & rise_en_i & ~fall_en_i) & ~$past(pin_i, 2)) == '0);
endmodule

// File: rtl/eirq_flag_bank.sv
`timescale 1ns/1ps
// Module: eirq_flag_bank
// Holds the pending and overrun flags. Clears are write-1; a new event
// wins over a clear on the same edge. An overrun uses the flag value
// before any same-cycle clear.
module eirq_flag_bank #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] clr_evt_i,
    input  logic [NUM_PINS-1:0] clr_ovr_i,
    input  logic [NUM_PINS-1:0] ovr_en_i,
    output logic [NUM_PINS-1:0] evt_stat_o,
    output logic [NUM_PINS-1:0] ovr_stat_o
);
    logic [NUM_PINS-1:0] evt_q, evt_d;
    logic [NUM_PINS-1:0] ovr_q, ovr_d;

    // Next-state: set dominates clear for both flag sets.
    always_comb begin
        evt_d = (evt_q & ~clr_evt_i) | evt_i;
        ovr_d = (ovr_q & ~clr_ovr_i) | (evt_i & evt_q & ovr_en_i);
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            ovr_q <= '0;
        end else begin
            evt_q <= evt_d;
            ovr_q <= ovr_d;
        end
    end

    assign evt_stat_o = evt_q;
    assign ovr_stat_o = ovr_q;

    // R7: every event seen is reflected as a pending bit one edge later.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_i |=> ((evt_q & $past(evt_i)) == $past(evt_i)));

    // R4/R6: pending bits change only where an event or clear arrived.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((evt_q ^ $past(evt_q)) & ~$past(evt_i | clr_evt_i)) == '0));

    // R8: a new overrun bit needs a pending flag and an armed enable.
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovr_q & ~$past(ovr_q) & ~$past(evt_q & ovr_en_i & evt_i)) == '0));
endmodule

// File: rtl/eirq_regs.sv
`timescale 1ns/1ps
// Module: eirq_regs
// Register port: four read/write enable registers, write-1 clear pulses for
// the two flag registers and a combinational read multiplexer.
// Assumes NUM_PINS does not exceed the data width.
module eirq_regs #(
    parameter int NUM_PINS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [eirq_pkg::REG_AW-1:0] addr_i,
    input  logic [eirq_pkg::REG_DW-1:0] wdata_i,
    output logic [eirq_pkg::REG_DW-1:0] rdata_o,
    input  logic [NUM_PINS-1:0]         evt_stat_i,
    input  logic [NUM_PINS-1:0]         ovr_stat_i,
    output logic [NUM_PINS-1:0]         req_en_o,
    output logic [NUM_PINS-1:0]         rise_en_o,
    output logic [NUM_PINS-1:0]         fall_en_o,
    output logic [NUM_PINS-1:0]         ovr_en_o,
    output logic [NUM_PINS-1:0]         clr_evt_o,
    output logic [NUM_PINS-1:0]         clr_ovr_o
);
    import eirq_pkg::*;

    localparam int PAD_W = REG_DW - NUM_PINS;

    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] rsel;

    assign wbits = wdata_i[NUM_PINS-1:0];

    // Enable registers, written whole on an address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_en_o  <= '0;
            rise_en_o <= '0;
            fall_en_o <= '0;
            ovr_en_o  <= '0;
        end else if (wr_i) begin
            if (addr_i == OFS_REQ_EN)  req_en_o  <= wbits;
            if (addr_i == OFS_RISE_EN) rise_en_o <= wbits;
            if (addr_i == OFS_FALL_EN) fall_en_o <= wbits;
            if (addr_i == OFS_OVR_EN)  ovr_en_o  <= wbits;
        end
    end

    // Write-1 clear pulses toward the flag bank.
    always_comb begin
        clr_evt_o = (wr_i && addr_i == OFS_EVT_STAT) ? wbits : '0;
        clr_ovr_o = (wr_i && addr_i == OFS_OVR_STAT) ? wbits : '0;
    end

    // Read selection by address; unmapped offsets read zero.
    always_comb begin
        unique case (addr_i)
            OFS_REQ_EN:   rsel = req_en_o;
            OFS_RISE_EN:  rsel = rise_en_o;
            OFS_FALL_EN:  rsel = fall_en_o;
            OFS_OVR_EN:   rsel = ovr_en_o;
            OFS_OVR_STAT: rsel = ovr_stat_i;
            OFS_EVT_STAT: rsel = evt_stat_i;
            default:      rsel = '0;
        endcase
    end

    if (PAD_W > 0) begin : g_pad
        assign rdata_o = {{PAD_W{1'b0}}, rsel};
    end else begin : g_nopad
        assign rdata_o = rsel;
    end

    // R6: a write of zero to the pending register never clears a bit.
    p_w0_noeffect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_EVT_STAT && wbits == '0) |=>
        ((~evt_stat_i & $past(evt_stat_i)) == '0));
endmodule

// File: rtl/ext_edge_irq_ctrl.sv
`timescale 1ns/1ps
// Module: ext_edge_irq_ctrl
// Top of the edge-triggered external interrupt controller: edge detection,
// flag bank and register port, plus request gating and the overrun line.
// Assumes a single clock domain for the register port.
module ext_edge_irq_ctrl #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pin_i,
    input  logic                reg_wr_i,
    input  logic [7:0]          reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic [NUM_PINS-1:0] irq_req_o,
    output logic                overrun_irq_o
);
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] evt_stat, ovr_stat;
    logic [NUM_PINS-1:0] req_en, rise_en, fall_en, ovr_en;
    logic [NUM_PINS-1:0] clr_evt, clr_ovr;

    eirq_edge_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (irq_pin_i),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .evt_o     (evt)
    );

    eirq_flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .clr_evt_i  (clr_evt),
        .clr_ovr_i  (clr_ovr),
        .ovr_en_i   (ovr_en),
        .evt_stat_o (evt_stat),
        .ovr_stat_o (ovr_stat)
    );

    eirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .evt_stat_i (evt_stat),
        .ovr_stat_i (ovr_stat),
        .req_en_o   (req_en),
        .rise_en_o  (rise_en),
        .fall_en_o  (fall_en),
        .ovr_en_o   (ovr_en),
        .clr_evt_o  (clr_evt),
        .clr_ovr_o  (clr_ovr)
    );

    // Request gating and the combined overrun line.
    always_comb begin
        irq_req_o     = evt_stat & req_en;
        overrun_irq_o = |ovr_stat;
    end

    // R9: the overrun line can only rise after a detected edge.
    p_ovr_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_irq_o) |-> $past(|evt));
endmodule

// File: tb/tb_ext_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_edge_irq_ctrl;
    localparam int N = 16;
    localparam logic [7:0] A_REQ = 8'h00, A_RISE = 8'h04, A_FALL = 8'h08,
                           A_OEN = 8'h0C, A_OVR = 8'h10, A_EVT = 8'h14;
    localparam logic [31:0] ALL = 32'h0000_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  irq_req;
    logic          ovr_irq;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    ext_edge_irq_ctrl #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(irq_req), .overrun_irq_o(ovr_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 8'hFF; wdata = '0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = 8'hFF;
    endtask

    // Change pins at a falling edge, then let synchronizer and flag settle.
    task automatic drive(input logic [N-1:0] p);
        @(negedge clk);
        pins = p;
        repeat (4) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        addr = 8'hFF;
        repeat (3) @(posedge clk);
        // R1: reset values on every register and output.
        for (int a = 0; a <= 'h14; a += 4) begin
            rreg(8'(a), rv);
            check("R1 reg after reset", rv, 32'h0);
        end
        check("R1 irq_req", {16'h0, irq_req}, 32'h0);
        check("R1 overrun", {31'h0, ovr_irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rreg(A_EVT, rv);
        check("R1 pending after release", rv, 32'h0);

        // R2/R3/R4/R5: sweep every pin under all four enable combinations.
        for (int c = 0; c < 4; c++) begin
            wreg(A_RISE, c[0] ? ALL : 32'h0);
            wreg(A_FALL, c[1] ? ALL : 32'h0);
            for (int i = 0; i < N; i++) begin
                drive(N'(1) << i);
                rreg(A_EVT, rv);
                check(c[0] ? "R2 rise sets" : "R4 rise ignored", rv,
                      c[0] ? (32'h1 << i) : 32'h0);
                drive('0);
                rreg(A_EVT, rv);
                check(c == 3 ? "R5 both edges" : (c[1] ? "R3 fall sets" : "R4 fall ignored"),
                      rv, (c != 0) ? (32'h1 << i) : 32'h0);
                wreg(A_EVT, ALL);
                rreg(A_EVT, rv);
                check("R6 clear by one", rv, 32'h0);
            end
        end

        // R2: exact latency, bit must be clear after two edges and set after three.
        wreg(A_RISE, ALL);
        wreg(A_FALL, 32'h0);
        @(negedge clk);
        pins = 16'h0010;
        @(posedge clk); @(posedge clk);
        #1 addr = A_EVT;
        #0.5 check("R2 not yet after two edges", rdata, 32'h0);
        @(posedge clk);
        #1 check("R2 set after third edge", rdata, 32'h10);
        addr = 8'hFF;
        drive('0);

        // R6: writing zero keeps the flag; R4: clearing enables keeps it too.
        wreg(A_EVT, 32'h0);
        rreg(A_EVT, rv);
        check("R6 write zero no effect", rv, 32'h10);
        wreg(A_RISE, 32'h0);
        drive(16'h0010);
        drive('0);
        rreg(A_EVT, rv);
        check("R4 flag kept with enables off", rv, 32'h10);
        rreg(A_OVR, rv);
        check("R4 no overrun when disabled", rv, 32'h0);
        wreg(A_EVT, ALL);

        // R10: request gating against the request enable register.
        wreg(A_RISE, ALL);
        wreg(A_REQ, 32'h0081);
        drive(16'h0089);
        check("R10 gated requests", {16'h0, irq_req}, 32'h0081);
        wreg(A_REQ, 32'h0008);
        check("R10 regated requests", {16'h0, irq_req}, 32'h0008);
        drive('0);
        wreg(A_EVT, ALL);
        check("R10 no request after clear", {16'h0, irq_req}, 32'h0);

        // R8/R9: overrun only with a pending flag and the overrun enable.
        wreg(A_OEN, 32'h0004);
        drive(16'h0024);
        drive('0);
        rreg(A_OVR, rv);
        check("R8 first edge no overrun", rv, 32'h0);
        drive(16'h0024);
        rreg(A_OVR, rv);
        check("R8 overrun only on enabled pin", rv, 32'h0004);
        check("R9 overrun line high", {31'h0, ovr_irq}, 32'h1);
        wreg(A_OVR, 32'h0);
        rreg(A_OVR, rv);
        check("R6 overrun write zero no effect", rv, 32'h0004);
        wreg(A_OVR, 32'h0004);
        rreg(A_OVR, rv);
        check("R6 overrun cleared", rv, 32'h0);
        check("R9 overrun line low", {31'h0, ovr_irq}, 32'h0);
        drive('0);
        wreg(A_EVT, ALL);
        wreg(A_OEN, 32'h0);

        // R7: event and clear on the same edge leaves the bit set.
        drive(16'h0080);
        drive('0);
        @(negedge clk);
        pins = 16'h0080;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = A_EVT; wdata = 32'h0080;
        @(negedge clk);
        wr = 1'b0; addr = 8'hFF; wdata = '0;
        rreg(A_EVT, rv);
        check("R7 set wins over clear", rv, 32'h0080);
        drive('0);
        wreg(A_EVT, ALL);

        // R11: read-back masking and unmapped addresses.
        wreg(A_FALL, 32'hFFFF_FFFF);
        rreg(A_FALL, rv);
        check("R11 upper bits read zero", rv, ALL);
        wreg(A_OEN, 32'h0000_A5C3);
        rreg(A_OEN, rv);
        check("R11 enable readback", rv, 32'h0000_A5C3);
        rreg(8'h18, rv);
        check("R11 unmapped reads zero", rv, 32'h0);
        rreg(8'h40, rv);
        check("R11 unmapped high reads zero", rv, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule